// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands commands to a power-management microcontroller and collects the answers. The host sits on a plain 32-bit register bus with a write strobe, a read strobe and a byte address. It loads up to two pointer words and up to four input words, then writes a command word. Writing the command word starts a transaction.

When the transaction starts, the block raises a one-cycle request toward the controller. The request carries the opcode, the sub-command, the byte length, both pointers and the input words. The controller later returns a one-cycle done pulse with an error flag, an 8-bit failure code and four result words. The status word tracks the transaction: busy, error, the completion-interrupt flag and the failure code. The host can poll busy. It can also ask for an interrupt level by setting a flag bit in the command word, and clear that interrupt by writing a one to it.

Failure codes are numbered as follows: 0 no failure, 1 unsupported, 2 not serviced, 3 cannot serve, 4 invalid, 5 generic failure, 6 security rejection, 7 unsigned image.

Top module: `cmd_mailbox`

## Requirements
- R1: After synchronous reset every readable register reads zero, `irq_o` is low and `req_valid` is low.
- R2: The register map is:
  - command at 0x00, status at 0x04, source pointer at 0x08 and destination pointer at 0x0C;
  - four input words at 0x80, 0x84, 0x88 and 0x8C;
  - four output words at 0x90, 0x94, 0x98 and 0x9C.

  `bus_rdata` shows the addressed value in the cycle after the edge that samples `bus_rd`. Any other offset, and any cycle without a read, gives zero.
- R3: The command word fields are:
  - opcode in bits 7:0;
  - interrupt request in bit 8;
  - sub-command in bits 15:12;
  - byte length in bits 20:16.

  An accepted command write makes `req_valid` high for exactly the next cycle. In that cycle `req_opcode`, `req_sub`, `req_len`, `req_sptr`, `req_dptr` and `req_data` carry the command fields, the two pointers and the input words. Input word i sits at `req_data` bits 32i+31:32i. A length above 16 is presented as 16.
- R4: An accepted command write sets status bit 0 (busy) and clears status bit 1 and bits 23:16. Busy stays set until a done pulse arrives while busy.
- R5: A done pulse while busy clears busy and copies `done_err` into status bit 1. Status bits 23:16 take `done_code` when `done_err` is set and zero otherwise.
- R6: The output words are loaded from `done_data` only on a done pulse with `done_err` low. After a failed completion they keep their earlier contents.
- R7: Status bit 2 is set on completion only if the accepted command had bit 8 set. `irq_o` is high exactly while status bit 2 is set.
- R8: Writing status with bit 2 high clears bit 2. Writing it with bit 2 low changes nothing. A completion in the same cycle as the clear leaves bit 2 set.
- R9: While busy, writes to the command, pointer and input-word registers are ignored and raise no second request.
- R10: A done pulse while not busy is ignored. It changes neither the status nor the output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W (8) | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| irq_o | output | 1 | Completion interrupt level |
| req_valid | output | 1 | One-cycle request to the controller |
| req_opcode | output | OP_W (8) | Request opcode |
| req_sub | output | SUB_W (4) | Request sub-command |
| req_len | output | LEN_W (5) | Request byte length, at most 16 |
| req_sptr | output | 32 | Request source pointer |
| req_dptr | output | 32 | Request destination pointer |
| req_data | output | 32*IN_WORDS (128) | Request input words |
| done_valid | input | 1 | Controller completion pulse |
| done_err | input | 1 | Completion failed |
| done_code | input | CODE_W (8) | Failure code |
| done_data | input | 32*OUT_WORDS (128) | Result words |

## Verification
The outputs are due at different times:
- Read data appears one cycle after the edge that samples `bus_rd`.
- The request pulse and its fields appear one cycle after the edge that accepts the command write.
- Busy, error, code, the interrupt level and the output words change at the edge that samples the done pulse.

A behavioural model in the bench updates at the same rising edge as the design and forms its expected read data from its own state before that edge. Every output is compared with the model at the following falling edge. Directed reads and pulse checks are placed at those same falling edges, so each result is sampled exactly one register stage after its cause.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Byte offsets of the host-visible registers
  localparam int unsigned OFF_CMD = 32'h00;
  localparam int unsigned OFF_STS = 32'h04;
  localparam int unsigned OFF_SRC = 32'h08;
  localparam int unsigned OFF_DST = 32'h0C;
  localparam int unsigned OFF_IN  = 32'h80;
  localparam int unsigned OFF_OUT = 32'h90;

  // Command word field positions
  localparam int unsigned CMD_IRQ_BIT = 8;
  localparam int unsigned CMD_SUB_LSB = 12;
  localparam int unsigned CMD_LEN_LSB = 16;

  // Status word field positions
  localparam int unsigned STS_BUSY     = 0;
  localparam int unsigned STS_ERR      = 1;
  localparam int unsigned STS_IRQ      = 2;
  localparam int unsigned STS_CODE_LSB = 16;

  typedef enum logic [7:0] {
    FAIL_NONE         = 8'd0,
    FAIL_UNSUPPORTED  = 8'd1,
    FAIL_NOT_SERVICED = 8'd2,
    FAIL_CANNOT_SERVE = 8'd3,
    FAIL_INVALID      = 8'd4,
    FAIL_GENERIC      = 8'd5,
    FAIL_SECURITY     = 8'd6,
    FAIL_UNSIGNED     = 8'd7
  } fail_code_e;

endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DW       = 32,
  parameter int IN_WORDS = 4,
  parameter int OP_W     = 8,
  parameter int SUB_W    = 4,
  parameter int LEN_W    = 5,
  parameter int MAX_LEN  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DW-1:0]          wdata,
  input  logic                   busy,
  output logic [DW-1:0]          cmd_q,
  output logic [DW-1:0]          sptr_q,
  output logic [DW-1:0]          dptr_q,
  output logic [IN_WORDS*DW-1:0] in_flat,
  output logic                   accept,
  output logic [OP_W-1:0]        acc_op,
  output logic [SUB_W-1:0]       acc_sub,
  output logic [LEN_W-1:0]       acc_len,
  output logic                   acc_irq,
  output logic                   irq_ack
);

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);
  localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(OFF_SRC);
  localparam logic [ADDR_W-1:0] A_DST = ADDR_W'(OFF_DST);
  localparam logic [LEN_W-1:0]  LEN_CAP = LEN_W'(MAX_LEN);

  logic            open_wr;
  logic [LEN_W-1:0] len_raw;

  // Writes to the transaction registers are only taken while idle
  assign open_wr = wr_en && !busy;
  assign accept  = open_wr && (addr == A_CMD);
  assign irq_ack = wr_en && (addr == A_STS) && wdata[STS_IRQ];

  assign acc_op  = wdata[OP_W-1:0];
  assign acc_sub = wdata[CMD_SUB_LSB +: SUB_W];
  assign acc_irq = wdata[CMD_IRQ_BIT];
  assign len_raw = wdata[CMD_LEN_LSB +: LEN_W];
  assign acc_len = (len_raw > LEN_CAP) ? LEN_CAP : len_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      sptr_q <= '0;
      dptr_q <= '0;
    end else begin
      if (accept)                     cmd_q  <= wdata;
      if (open_wr && addr == A_SRC)   sptr_q <= wdata;
      if (open_wr && addr == A_DST)   dptr_q <= wdata;
    end
  end

  for (genvar gi = 0; gi < IN_WORDS; gi++) begin : g_in
    localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(OFF_IN + 4 * gi);
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)                         word_q <= '0;
      else if (open_wr && addr == A_WORD) word_q <= wdata;
    end
    assign in_flat[gi*DW +: DW] = word_q;
  end

endmodule

// File: rtl/mbx_txn.sv
module mbx_txn
  import mbx_pkg::*;
#(
  parameter int DW       = 32,
  parameter int IN_WORDS = 4,
  parameter int OP_W     = 8,
  parameter int SUB_W    = 4,
  parameter int LEN_W    = 5,
  parameter int CODE_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  logic [OP_W-1:0]        acc_op,
  input  logic [SUB_W-1:0]       acc_sub,
  input  logic [LEN_W-1:0]       acc_len,
  input  logic                   acc_irq,
  input  logic                   irq_ack,
  input  logic [DW-1:0]          sptr_q,
  input  logic [DW-1:0]          dptr_q,
  input  logic [IN_WORDS*DW-1:0] in_flat,
  input  logic                   done_valid,
  input  logic                   done_err,
  input  logic [CODE_W-1:0]      done_code,
  output logic                   busy,
  output logic                   err,
  output logic [CODE_W-1:0]      code,
  output logic                   irq_flag,
  output logic                   load_out,
  output logic                   req_valid,
  output logic [OP_W-1:0]        req_op,
  output logic [SUB_W-1:0]       req_sub,
  output logic [LEN_W-1:0]       req_len,
  output logic [DW-1:0]          req_sptr,
  output logic [DW-1:0]          req_dptr,
  output logic [IN_WORDS*DW-1:0] req_data
);

  logic irq_en;
  logic finish;

  assign finish   = busy && done_valid;
  assign load_out = finish && !done_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      err       <= 1'b0;
      code      <= '0;
      irq_en    <= 1'b0;
      irq_flag  <= 1'b0;
      req_valid <= 1'b0;
      req_op    <= '0;
      req_sub   <= '0;
      req_len   <= '0;
      req_sptr  <= '0;
      req_dptr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= 1'b0;
      // Clear first so that a completion in the same cycle wins
      if (irq_ack) irq_flag <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        err       <= 1'b0;
        code      <= CODE_W'(FAIL_NONE);
        irq_en    <= acc_irq;
        req_valid <= 1'b1;
        req_op    <= acc_op;
        req_sub   <= acc_sub;
        req_len   <= acc_len;
        req_sptr  <= sptr_q;
        req_dptr  <= dptr_q;
        req_data  <= in_flat;
      end else if (finish) begin
        busy <= 1'b0;
        err  <= done_err;
        code <= done_err ? done_code : CODE_W'(FAIL_NONE);
        if (irq_en) irq_flag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mbx_outbuf.sv
module mbx_outbuf #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [WORDS*DW-1:0] din,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [DW-1:0]       rd_data
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= din[i*DW +: DW];
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IN_WORDS  = 4,
  parameter int OUT_WORDS = 4,
  parameter int OP_W      = 8,
  parameter int SUB_W     = 4,
  parameter int LEN_W     = 5,
  parameter int CODE_W    = 8,
  parameter int MAX_LEN   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    irq_o,
  output logic                    req_valid,
  output logic [OP_W-1:0]         req_opcode,
  output logic [SUB_W-1:0]        req_sub,
  output logic [LEN_W-1:0]        req_len,
  output logic [31:0]             req_sptr,
  output logic [31:0]             req_dptr,
  output logic [32*IN_WORDS-1:0]  req_data,
  input  logic                    done_valid,
  input  logic                    done_err,
  input  logic [CODE_W-1:0]       done_code,
  input  logic [32*OUT_WORDS-1:0] done_data
);

  localparam int DW      = 32;
  localparam int OUT_IDX = (OUT_WORDS > 1) ? $clog2(OUT_WORDS) : 1;
  localparam int IN_IDX  = (IN_WORDS > 1) ? $clog2(IN_WORDS) : 1;
  localparam int IN_END  = OFF_IN + 4 * IN_WORDS;
  localparam int OUT_END = OFF_OUT + 4 * OUT_WORDS;

  logic [DW-1:0]          cmd_w, sptr_w, dptr_w;
  logic [IN_WORDS*DW-1:0] in_w;
  logic                   accept_w, acc_irq_w, irq_ack_w;
  logic [OP_W-1:0]        acc_op_w;
  logic [SUB_W-1:0]       acc_sub_w;
  logic [LEN_W-1:0]       acc_len_w;
  logic                   busy_w, err_w, irq_w, load_w;
  logic [CODE_W-1:0]      code_w;
  logic [DW-1:0]          out_word;
  logic [OUT_IDX-1:0]     out_idx;
  logic [IN_IDX-1:0]      in_idx;
  logic [31:0]            a_ext;
  logic [DW-1:0]          sts_word;
  logic [DW-1:0]          rd_mux;

  mbx_host_regs #(
    .ADDR_W(ADDR_W), .DW(DW), .IN_WORDS(IN_WORDS), .OP_W(OP_W),
    .SUB_W(SUB_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy_w), .cmd_q(cmd_w), .sptr_q(sptr_w), .dptr_q(dptr_w),
    .in_flat(in_w), .accept(accept_w), .acc_op(acc_op_w), .acc_sub(acc_sub_w),
    .acc_len(acc_len_w), .acc_irq(acc_irq_w), .irq_ack(irq_ack_w)
  );

  mbx_txn #(
    .DW(DW), .IN_WORDS(IN_WORDS), .OP_W(OP_W), .SUB_W(SUB_W),
    .LEN_W(LEN_W), .CODE_W(CODE_W)
  ) u_txn (
    .clk(clk), .rst(rst), .accept(accept_w), .acc_op(acc_op_w),
    .acc_sub(acc_sub_w), .acc_len(acc_len_w), .acc_irq(acc_irq_w),
    .irq_ack(irq_ack_w), .sptr_q(sptr_w), .dptr_q(dptr_w), .in_flat(in_w),
    .done_valid(done_valid), .done_err(done_err), .done_code(done_code),
    .busy(busy_w), .err(err_w), .code(code_w), .irq_flag(irq_w),
    .load_out(load_w), .req_valid(req_valid), .req_op(req_opcode),
    .req_sub(req_sub), .req_len(req_len), .req_sptr(req_sptr),
    .req_dptr(req_dptr), .req_data(req_data)
  );

  mbx_outbuf #(.DW(DW), .WORDS(OUT_WORDS)) u_out (
    .clk(clk), .rst(rst), .load(load_w), .din(done_data),
    .rd_idx(out_idx), .rd_data(out_word)
  );

  assign irq_o   = irq_w;
  assign a_ext   = 32'(bus_addr);
  assign out_idx = OUT_IDX'((a_ext - OFF_OUT) >> 2);
  assign in_idx  = IN_IDX'((a_ext - OFF_IN) >> 2);

  always_comb begin
    sts_word = '0;
    sts_word[STS_BUSY] = busy_w;
    sts_word[STS_ERR]  = err_w;
    sts_word[STS_IRQ]  = irq_w;
    sts_word[STS_CODE_LSB +: CODE_W] = code_w;
  end

  always_comb begin
    rd_mux = '0;
    if (a_ext[1:0] == 2'b00) begin
      if      (a_ext == OFF_CMD) rd_mux = cmd_w;
      else if (a_ext == OFF_STS) rd_mux = sts_word;
      else if (a_ext == OFF_SRC) rd_mux = sptr_w;
      else if (a_ext == OFF_DST) rd_mux = dptr_w;
      else if (a_ext >= OFF_IN && a_ext < IN_END)   rd_mux = in_w[in_idx*DW +: DW];
      else if (a_ext >= OFF_OUT && a_ext < OUT_END) rd_mux = out_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_mux : '0;
  end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              busy,
  input logic              status_err,
  input logic [31:0]       sptr,
  input logic              req_valid,
  input logic              irq_o,
  input logic              done_valid,
  input logic              done_err
);

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(OFF_SRC);

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  assert_busy_set_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CMD && !busy) |=> (busy && req_valid));

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done_valid));

  assert_done_err_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && done_valid) |=> (!busy && status_err == $past(done_err)));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(done_valid && busy));

  assert_busy_ptr_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == A_SRC) |=> $stable(sptr));

  assert_busy_noreq_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_valid) |=> !req_valid);

  assert_idle_done_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && done_valid && !(bus_wr && bus_addr == A_CMD)) |=> !busy);

endmodule

bind cmd_mailbox mbx_checker #(.ADDR_W(ADDR_W)) u_mbx_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .busy(busy_w), .status_err(err_w), .sptr(sptr_w), .req_valid(req_valid),
  .irq_o(irq_o), .done_valid(done_valid), .done_err(done_err)
);

// File: tb/test_cmd_mailbox.sv
module test_cmd_mailbox;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq_o, req_valid;
  logic [7:0]   req_opcode;
  logic [3:0]   req_sub;
  logic [4:0]   req_len;
  logic [31:0]  req_sptr, req_dptr;
  logic [127:0] req_data;
  logic         done_valid = 1'b0, done_err = 1'b0;
  logic [7:0]   done_code = '0;
  logic [127:0] done_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_on  = 1'b0;

  always #10 clk = ~clk;

  cmd_mailbox i_cmd_mailbox (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_sub(req_sub), .req_len(req_len), .req_sptr(req_sptr),
    .req_dptr(req_dptr), .req_data(req_data), .done_valid(done_valid),
    .done_err(done_err), .done_code(done_code), .done_data(done_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        m_busy = 0, m_err = 0, m_irq = 0, m_irqen = 0;
  logic [7:0]  m_code = 0;
  logic [31:0] m_cmd = 0, m_sp = 0, m_dp = 0;
  logic [31:0] m_in [4] = '{default: 0};
  logic [31:0] m_out [4] = '{default: 0};
  logic [31:0] e_rdata = 0;
  logic        e_req = 0;
  logic [7:0]  e_op = 0;
  logic [3:0]  e_sub = 0;
  logic [4:0]  e_len = 0;
  logic [31:0] e_sp = 0, e_dp = 0;
  logic [31:0] e_data [4] = '{default: 0};

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return m_cmd;
      8'h04: return {8'h00, m_code, 13'h0, m_irq, m_err, m_busy};
      8'h08: return m_sp;
      8'h0C: return m_dp;
      8'h80, 8'h84, 8'h88, 8'h8C: return m_in[(a - 8'h80) >> 2];
      8'h90, 8'h94, 8'h98, 8'h9C: return m_out[(a - 8'h90) >> 2];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic b0;
    if (rst) begin
      m_busy = 0; m_err = 0; m_irq = 0; m_irqen = 0; m_code = 0;
      m_cmd = 0; m_sp = 0; m_dp = 0;
      for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
      e_rdata = 0; e_req = 0;
    end else begin
      b0 = m_busy;
      e_rdata = bus_rd ? mread(bus_addr) : 32'h0;
      e_req = 0;
      if (bus_wr) begin
        if (bus_addr == 8'h04 && bus_wdata[2]) m_irq = 0;
        if (!b0) begin
          case (bus_addr)
            8'h00: begin
              m_cmd = bus_wdata; m_busy = 1; m_err = 0; m_code = 0;
              m_irqen = bus_wdata[8]; e_req = 1;
              e_op = bus_wdata[7:0]; e_sub = bus_wdata[15:12];
              e_len = (bus_wdata[20:16] > 16) ? 5'd16 : bus_wdata[20:16];
              e_sp = m_sp; e_dp = m_dp;
              for (int i = 0; i < 4; i++) e_data[i] = m_in[i];
            end
            8'h08: m_sp = bus_wdata;
            8'h0C: m_dp = bus_wdata;
            8'h80, 8'h84, 8'h88, 8'h8C: m_in[(bus_addr - 8'h80) >> 2] = bus_wdata;
            default: ;
          endcase
        end
      end
      if (b0 && done_valid) begin
        m_busy = 0; m_err = done_err;
        m_code = done_err ? done_code : 8'h0;
        if (m_irqen) m_irq = 1;
        if (!done_err) for (int i = 0; i < 4; i++) m_out[i] = done_data[i*32 +: 32];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 read data vs model", bus_rdata, e_rdata);
      chk("R7 irq level vs model", 32'(irq_o), 32'(m_irq));
      chk("R3 request pulse vs model", 32'(req_valid), 32'(e_req));
      if (e_req) begin
        chk("R3 opcode", 32'(req_opcode), 32'(e_op));
        chk("R3 sub-command", 32'(req_sub), 32'(e_sub));
        chk("R3 length", 32'(req_len), 32'(e_len));
        chk("R3 source pointer", req_sptr, e_sp);
        chk("R3 destination pointer", req_dptr, e_dp);
        for (int i = 0; i < 4; i++) chk("R3 input word", req_data[i*32 +: 32], e_data[i]);
      end
    end
  end

  // ---------------- stimulus tasks (entered at a falling edge) ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic respond(input logic e, input logic [7:0] c, input logic [127:0] d);
    done_valid = 1; done_err = e; done_code = c; done_data = d;
    @(negedge clk);
    done_valid = 0; done_err = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  localparam logic [127:0] RES_A = {32'hD4D4_0004, 32'hC3C3_0003, 32'hB2B2_0002, 32'hA1A1_0001};
  localparam logic [127:0] RES_B = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};

  initial begin
    @(posedge clk); #1 cmp_on = 1;
    repeat (2) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq_o), 0);
    chk("R1 request after reset", 32'(req_valid), 0);
    rd_chk("R1 command reset", 8'h00, 0);
    rd_chk("R1 status reset", 8'h04, 0);
    rd_chk("R1 output word reset", 8'h90, 0);

    // R2 map and readback
    wr(8'h08, 32'hA5A5_0001);
    wr(8'h0C, 32'h5A5A_0002);
    for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4 * i), 32'h1000_0000 + 32'(i));
    rd_chk("R2 source pointer", 8'h08, 32'hA5A5_0001);
    rd_chk("R2 destination pointer", 8'h0C, 32'h5A5A_0002);
    rd_chk("R2 input word 2", 8'h88, 32'h1000_0002);
    rd_chk("R2 unmapped 0x40", 8'h40, 0);
    rd_chk("R2 unmapped 0xA0", 8'hA0, 0);

    // R3 command with interrupt, length 20 capped to 16
    wr(8'h00, 32'h0014_513C);
    chk("R3 request pulse", 32'(req_valid), 1);
    chk("R3 length capped", 32'(req_len), 16);
    chk("R3 opcode", 32'(req_opcode), 32'h3C);
    chk("R3 sub-command", 32'(req_sub), 5);
    chk("R3 input word 3", req_data[127:96], 32'h1000_0003);
    rd_chk("R4 busy set", 8'h04, 32'h1);
    chk("R3 pulse is single", 32'(req_valid), 0);

    // R9 writes while busy are ignored
    wr(8'h08, 32'hDEAD_BEEF);
    wr(8'h80, 32'hDEAD_BEEF);
    wr(8'h00, 32'h0004_0011);
    chk("R9 no second request", 32'(req_valid), 0);
    rd_chk("R9 pointer kept", 8'h08, 32'hA5A5_0001);
    rd_chk("R9 input word kept", 8'h80, 32'h1000_0000);
    rd_chk("R9 command kept", 8'h00, 32'h0014_513C);

    // R5 R6 R7 success with interrupt; nonzero code must read zero
    respond(1'b0, 8'h05, RES_A);
    chk("R7 irq raised", 32'(irq_o), 1);
    rd_chk("R5 status after success", 8'h04, 32'h4);
    rd_chk("R6 output word 0", 8'h90, 32'hA1A1_0001);
    rd_chk("R6 output word 3", 8'h9C, 32'hD4D4_0004);

    // R8 write-one-to-clear
    wr(8'h04, 32'h0000_0003);
    chk("R8 zero in bit 2 keeps irq", 32'(irq_o), 1);
    wr(8'h04, 32'h0000_0004);
    chk("R8 clear irq", 32'(irq_o), 0);
    rd_chk("R8 status after clear", 8'h04, 0);

    // R5 R6 R7 failure without interrupt, length 8
    wr(8'h00, 32'h0008_2011);
    chk("R3 length 8", 32'(req_len), 8);
    repeat (3) @(negedge clk);
    respond(1'b1, 8'h06, RES_B);
    chk("R7 no irq without request bit", 32'(irq_o), 0);
    rd_chk("R5 status after failure", 8'h04, 32'h0006_0002);
    rd_chk("R6 output kept after failure", 8'h94, 32'hB2B2_0002);

    // R10 stray completion while idle
    respond(1'b0, 8'h00, RES_B);
    rd_chk("R10 status unchanged", 8'h04, 32'h0006_0002);
    rd_chk("R10 output unchanged", 8'h90, 32'hA1A1_0001);

    // R8 completion wins over simultaneous clear
    wr(8'h00, 32'h0000_0101);
    respond(1'b0, 8'h00, RES_B);
    chk("R7 irq raised again", 32'(irq_o), 1);
    wr(8'h00, 32'h0000_0102);
    bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h4;
    done_valid = 1; done_err = 0; done_data = RES_A;
    @(negedge clk);
    bus_wr = 0; done_valid = 0;
    chk("R8 completion beats clear", 32'(irq_o), 1);
    rd_chk("R4 busy dropped", 8'h04, 32'h4);
    rd_chk("R6 output reloaded", 8'h98, 32'hC3C3_0003);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule